// File: doc/BRIEF.md
# Host-Controller Mailbox with Doorbells

This block is a register-mapped message window shared by a host processor and an embedded controller. Eight 64-bit mailbox words hold message payloads: by convention words 0 to 3 carry a host request and words 4 to 7 carry the controller's response. The block does not enforce that split, so any bus master may write any word.

Two 64-bit doorbells carry the signalling. One runs from the host to the controller and the other from the controller to the host. Each doorbell sits behind three bus addresses:

- a plain alias that overwrites the doorbell;
- a clear alias that ANDs the write data into the doorbell;
- a set alias that ORs the write data into the doorbell.

The clear and set aliases let either side change single bits without a read-modify-write sequence.

Bit 0 is the most significant bit of each doorbell. The defined bits of a doorbell drive a level interrupt toward its receiver. For the host-to-controller doorbell, bit 0 means a request is waiting. For the controller-to-host doorbell, bit 0 means a response is waiting, bit 1 means the request was taken, and bit 2 asks the host to wake its primary thread.

The bus is synchronous and single-cycle. Read data is combinational from the current register contents. Writes take effect at the clock edge.

Top module: `mbx_doorbell_top`

## Requirements
- R1: A synchronous reset, active high, clears every mailbox word and both doorbells to zero. Both interrupts are low after reset.
- R2: Mailbox word k (k = 0..7) decodes at address 0x0D0050 + k. A write stores all 64 bits, and a read returns them in the cycle after the write edge.
- R3: A write to 0x0D0060 (host-to-controller) or to 0x0D0063 (controller-to-host) replaces that doorbell with the write data.
- R4: A write to 0x0D0061 or to 0x0D0064 replaces the matching doorbell with (old value AND write data). For example, mask 0x7FFFFFFFFFFFFFFF clears bit 0 only.
- R5: A write to 0x0D0062 or to 0x0D0065 replaces the matching doorbell with (old value OR write data).
- R6: A read at any of a doorbell's three addresses returns that doorbell's current value.
- R7: `irq_to_ctrl` is high exactly while bit 0 (mask 0x8000000000000000) of the host-to-controller doorbell is set.
- R8: `irq_to_host` is high exactly while any of bits 0, 1 or 2 (masks 0x8000000000000000, 0x4000000000000000, 0x2000000000000000) of the controller-to-host doorbell is set. It stays high until software clears every one of them.
- R9: Doorbell bits outside the defined ones are stored and read back, but they never raise an interrupt.
- R10: A read from an address outside both windows returns zero. A write there changes no register.
- R11: A cycle with `bus_we` low changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 24 | Word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data for `bus_addr`, combinational |
| irq_to_ctrl | output | 1 | Level interrupt toward the controller |
| irq_to_host | output | 1 | Level interrupt toward the host |

## Verification
Read data reflects the current address in the same cycle. A write, and the interrupt level that follows from it, become visible one cycle later, after the edge that stores the write. The bench applies each bus operation just after a falling edge. It compares read data and both interrupts against its own model a nanosecond later. The model absorbs the write only at the next rising edge, so every comparison matches the one-edge latency.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 24;
    localparam int NUM_MBX = 8;
    localparam int NUM_DB = 2;
    localparam int ALIASES = 3;
    localparam logic [ADDR_W-1:0] MBX_BASE = 24'h0D0050;
    localparam logic [ADDR_W-1:0] DB_BASE = 24'h0D0060;

    // Big-endian bit numbering: bit 0 is the MSB.
    function automatic logic [DATA_W-1:0] msb_bit(input int n);
        return {{(DATA_W-1){1'b0}}, 1'b1} << (DATA_W - 1 - n);
    endfunction

    typedef enum logic [1:0] {
        DB_NONE = 2'd0,
        DB_RW = 2'd1,
        DB_AND = 2'd2,
        DB_OR = 2'd3
    } db_op_e;

    typedef struct packed {
        logic hit_mbx;
        logic [$clog2(NUM_MBX)-1:0] mbx_idx;
        logic hit_db;
        logic [$clog2(NUM_DB)-1:0] db_sel;
        db_op_e op;
    } dec_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input logic [ADDR_W-1:0] addr,
    output dec_t dec
);
    localparam int DB_SPAN = NUM_DB * ALIASES;

    logic [ADDR_W-1:0] mbx_off;
    logic [ADDR_W-1:0] db_off;

    always_comb begin
        mbx_off = addr - MBX_BASE;
        db_off = addr - DB_BASE;
        dec = '0;
        dec.op = DB_NONE;

        if (addr >= MBX_BASE && mbx_off < ADDR_W'(NUM_MBX)) begin
            dec.hit_mbx = 1'b1;
            dec.mbx_idx = mbx_off[$clog2(NUM_MBX)-1:0];
        end

        if (addr >= DB_BASE && db_off < ADDR_W'(DB_SPAN)) begin
            dec.hit_db = 1'b1;
            dec.db_sel = $clog2(NUM_DB)'(db_off / ADDR_W'(ALIASES));
            case (db_off % ADDR_W'(ALIASES))
                ADDR_W'(0): dec.op = DB_RW;
                ADDR_W'(1): dec.op = DB_AND;
                default: dec.op = DB_OR;
            endcase
        end
    end

    always_comb begin
        assert ($onehot0({dec.hit_mbx, dec.hit_db})) else $error("p_single_hit_r10");
    end
endmodule

// File: rtl/mbx_regfile.sv
module mbx_regfile
    import mbx_pkg::*;
#(
    parameter int N = NUM_MBX,
    parameter int W = DATA_W
) (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic [$clog2(N)-1:0] wr_idx,
    input logic [W-1:0] wr_data,
    output logic [N-1:0][W-1:0] words
);
    logic [N-1:0][W-1:0] words_d, words_q;

    always_comb begin
        words_d = words_q;
        if (wr_en) begin
            words_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q <= '0;
        end else begin
            words_q <= words_d;
        end
    end

    assign words = words_q;

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(words_q));

    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> words_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/mbx_doorbell.sv
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int W = DATA_W,
    parameter logic [W-1:0] IRQ_MASK = '0
) (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input db_op_e op,
    input logic [W-1:0] wr_data,
    output logic [W-1:0] value,
    output logic irq
);
    typedef struct packed {
        logic [W-1:0] bits;
    } db_state_t;

    db_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (op)
                DB_RW: st_d.bits = wr_data;
                DB_AND: st_d.bits = st_q.bits & wr_data;
                DB_OR: st_d.bits = st_q.bits | wr_data;
                default: st_d.bits = st_q.bits;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.bits;
    assign irq = |(st_q.bits & IRQ_MASK);

    p_and_merge_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == DB_AND) |=> value == ($past(value) & $past(wr_data)));

    p_or_merge_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && op == DB_OR) |=> value == ($past(value) | $past(wr_data)));

    p_irq_held_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_en) |=> irq);

    p_or_keeps_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (irq && wr_en && op == DB_OR) |=> irq);
endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top
    import mbx_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic [23:0] bus_addr,
    input logic bus_we,
    input logic [63:0] bus_wdata,
    output logic [63:0] bus_rdata,
    output logic irq_to_ctrl,
    output logic irq_to_host
);
    localparam logic [DATA_W-1:0] H2C_MASK = msb_bit(0);
    localparam logic [DATA_W-1:0] C2H_MASK = msb_bit(0) | msb_bit(1) | msb_bit(2);
    localparam logic [NUM_DB-1:0][DATA_W-1:0] DB_MASKS = {C2H_MASK, H2C_MASK};

    dec_t dec;
    logic [NUM_MBX-1:0][DATA_W-1:0] mbx_words;
    logic [NUM_DB-1:0][DATA_W-1:0] db_val;
    logic [NUM_DB-1:0] db_irq;

    mbx_decode u_dec (
        .addr(bus_addr),
        .dec(dec)
    );

    mbx_regfile #(.N(NUM_MBX), .W(DATA_W)) u_regs (
        .clk(clk),
        .rst(rst),
        .wr_en(bus_we && dec.hit_mbx),
        .wr_idx(dec.mbx_idx),
        .wr_data(bus_wdata),
        .words(mbx_words)
    );

    for (genvar g = 0; g < NUM_DB; g++) begin : g_db
        mbx_doorbell #(.W(DATA_W), .IRQ_MASK(DB_MASKS[g])) u_db (
            .clk(clk),
            .rst(rst),
            .wr_en(bus_we && dec.hit_db && dec.db_sel == $clog2(NUM_DB)'(g)),
            .op(dec.op),
            .wr_data(bus_wdata),
            .value(db_val[g]),
            .irq(db_irq[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (dec.hit_mbx) begin
            bus_rdata = mbx_words[dec.mbx_idx];
        end else if (dec.hit_db) begin
            bus_rdata = db_val[dec.db_sel];
        end
    end

    assign irq_to_ctrl = db_irq[0];
    assign irq_to_host = db_irq[1];

    p_undecoded_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !(dec.hit_mbx || dec.hit_db) |-> bus_rdata == '0);

    p_ctrl_irq_bit0_r7: assert property (@(posedge clk) disable iff (rst)
        irq_to_ctrl |-> db_val[0][DATA_W-1]);
endmodule

// File: tb/sim_mbx_doorbell_top.sv
module sim_mbx_doorbell_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [23:0] bus_addr = '0;
    logic bus_we = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic irq_to_ctrl;
    logic irq_to_host;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [63:0] m_mb [8];
    logic [63:0] m_h2c;
    logic [63:0] m_c2h;

    always #2 clk = ~clk;

    mbx_doorbell_top u0 (
        .clk(clk),
        .rst(rst),
        .bus_addr(bus_addr),
        .bus_we(bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_to_ctrl(irq_to_ctrl),
        .irq_to_host(irq_to_host)
    );

    function automatic logic [63:0] m_read(input logic [23:0] a);
        if (a >= 24'h0D0050 && a <= 24'h0D0057) return m_mb[a - 24'h0D0050];
        if (a >= 24'h0D0060 && a <= 24'h0D0062) return m_h2c;
        if (a >= 24'h0D0063 && a <= 24'h0D0065) return m_c2h;
        return 64'h0;
    endfunction

    task automatic m_write(input logic [23:0] a, input logic [63:0] d);
        if (a >= 24'h0D0050 && a <= 24'h0D0057) m_mb[a - 24'h0D0050] = d;
        else if (a == 24'h0D0060) m_h2c = d;
        else if (a == 24'h0D0061) m_h2c = m_h2c & d;
        else if (a == 24'h0D0062) m_h2c = m_h2c | d;
        else if (a == 24'h0D0063) m_c2h = d;
        else if (a == 24'h0D0064) m_c2h = m_c2h & d;
        else if (a == 24'h0D0065) m_c2h = m_c2h | d;
    endtask

    task automatic step(input logic [23:0] a, input logic we, input logic [63:0] d, input string tag);
        logic [63:0] er;
        logic ec, eh;
        @(negedge clk);
        bus_addr = a;
        bus_we = we;
        bus_wdata = d;
        #1;
        er = m_read(a);
        ec = m_h2c[63];
        eh = |m_c2h[63:61];
        checks++;
        if (bus_rdata !== er || irq_to_ctrl !== ec || irq_to_host !== eh) begin
            fails++;
            $display("FAIL %s addr=%h rdata=%h exp=%h irq_ctrl=%b exp=%b irq_host=%b exp=%b",
                     tag, a, bus_rdata, er, irq_to_ctrl, ec, irq_to_host, eh);
        end
        @(posedge clk);
        if (we) m_write(a, d);
    endtask

    task automatic rd(input logic [23:0] a, input string tag);
        step(a, 1'b0, 64'h0, tag);
    endtask

    task automatic wr(input logic [23:0] a, input logic [63:0] d, input string tag);
        step(a, 1'b1, d, tag);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_mb[i] = '0;
        m_h2c = '0;
        m_c2h = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: all zero after reset, interrupts low
        for (int i = 0; i < 8; i++) rd(24'h0D0050 + 24'(i), "R1");
        for (int i = 0; i < 6; i++) rd(24'h0D0060 + 24'(i), "R1");

        // R2: distinct patterns in every mailbox word
        for (int i = 0; i < 8; i++) wr(24'h0D0050 + 24'(i), {32'hA5A50000 + 32'(i), 32'h0F0F_F0F0 ^ 32'(i * 7)}, "R2");
        for (int i = 0; i < 8; i++) rd(24'h0D0050 + 24'(i), "R2");

        // R11: bus_we low with data present
        step(24'h0D0053, 1'b0, 64'hDEAD_BEEF_DEAD_BEEF, "R11");
        step(24'h0D0060, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R11");
        rd(24'h0D0053, "R11");
        rd(24'h0D0060, "R11");

        // R7 R3: host request sets bit 0 of the host-to-controller doorbell
        wr(24'h0D0060, 64'h8000_0000_0000_0000, "R3");
        rd(24'h0D0060, "R7");
        rd(24'h0D0061, "R6");
        rd(24'h0D0062, "R6");

        // R4: controller clears bit 0 with the AND mask
        wr(24'h0D0061, 64'h7FFF_FFFF_FFFF_FFFF, "R4");
        rd(24'h0D0060, "R4");

        // R9: undefined bits stored, no interrupt
        wr(24'h0D0062, 64'h1000_0000_0000_00FF, "R9");
        rd(24'h0D0060, "R9");
        wr(24'h0D0063, 64'h1FFF_FFFF_FFFF_FFFF, "R9");
        rd(24'h0D0065, "R9");

        // R5 R8: set bits 1, 0, 2 one at a time, then clear them one at a time
        wr(24'h0D0065, 64'h4000_0000_0000_0000, "R5");
        wr(24'h0D0065, 64'h8000_0000_0000_0000, "R5");
        wr(24'h0D0065, 64'h2000_0000_0000_0000, "R8");
        rd(24'h0D0064, "R6");
        wr(24'h0D0064, 64'h7FFF_FFFF_FFFF_FFFF, "R8");
        wr(24'h0D0064, 64'hBFFF_FFFF_FFFF_FFFF, "R8");
        rd(24'h0D0063, "R8");
        wr(24'h0D0064, 64'hDFFF_FFFF_FFFF_FFFF, "R8");
        rd(24'h0D0063, "R8");

        // R3: a plain write replaces the whole value
        wr(24'h0D0063, 64'h0123_4567_89AB_CDEF, "R3");
        rd(24'h0D0063, "R3");
        wr(24'h0D0060, 64'hC000_0000_0000_0001, "R3");
        rd(24'h0D0062, "R7");

        // R10: addresses outside both windows
        rd(24'h0D004F, "R10");
        rd(24'h0D0058, "R10");
        rd(24'h0D0066, "R10");
        wr(24'h0D0058, 64'hFFFF_FFFF_FFFF_FFFF, "R10");
        wr(24'h0D0066, 64'h0, "R10");
        wr(24'h0D005F, 64'h0, "R10");
        for (int i = 0; i < 8; i++) rd(24'h0D0050 + 24'(i), "R10");
        rd(24'h0D0060, "R10");
        rd(24'h0D0063, "R10");

        // R1: reset again in the middle of traffic
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int i = 0; i < 8; i++) m_mb[i] = '0;
        m_h2c = '0;
        m_c2h = '0;
        @(negedge clk);
        rst = 1'b0;
        rd(24'h0D0060, "R1");
        rd(24'h0D0063, "R1");
        rd(24'h0D0057, "R1");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule